// File: doc/BRIEF.md
# Superscalar Dispatch Stall Controller

This block sits between an in-order queue of decoded instructions and the out-of-order schedulers. Each cycle it looks at the oldest instructions at the queue head, one per slot, and accepts the longest run of them that fits every resource budget at once. The budgets are the group width (counted in micro-ops), free reorder-buffer entries, free rename registers, scheduler entries, and load-queue and store-queue entries. Acceptance is a prefix of the slots: the first instruction that does not fit ends the group for that cycle.

When a valid instruction is refused for a reason other than a full group, the cycle is charged to one stall cause. A fixed priority picks that cause when several budgets are short at once. One saturating counter per cause and a histogram of micro-ops dispatched per cycle are kept. A synchronous clear input resets them all. The group width, the rename-register mode, the credit widths and the counter width are parameters. A width setting of zero selects a default width.

Top module: `disp_ctrl`

## Requirements
- R1: Accepted slots form a prefix of the presented slots (take_o bit i set implies bits below i set), only valid slots are accepted, and acceptance stops at the first slot that fails any check.
- R2: The micro-ops of one group never exceed the width W. W equals WIDTH_CFG, or DEF_WIDTH when WIDTH_CFG is 0. Stopping on width charges no stall.
- R3: The accepted group's total micro-op count never exceeds rob_free_i.
- R4: The accepted group never holds more instructions with the destination flag set than reg_free_i. When RENAME_REGS is 0, rename registers are unlimited and reg_free_i is ignored.
- R5: The accepted group's total micro-op count never exceeds sched_free_i.
- R6: Kind code 1 (load) uses one load-queue entry and kind code 2 (store) uses one store-queue entry. The group never holds more loads than lq_free_i or more stores than sq_free_i.
- R7: An instruction with the solo flag dispatches only from slot 0, and no instruction follows it in the same group.
- R8: cause_o gives the reason the first refused valid slot was refused. The codes are 1 reorder buffer, 2 register, 3 scheduler, 4 load queue, 5 store queue and 6 group restriction. When several checks fail, the lowest code wins. cause_o is 0 when nothing valid is refused or when the width stops the group.
- R9: stall_cnt_o entry c counts the clock cycles in which cause_o equals c+1.
- R10: hist_o entry n counts the clock cycles in which exactly n micro-ops were dispatched, for n from 0 to W.
- R11: All counters are zero after reset. They hold at their all-ones value instead of wrapping. clr_i zeroes them on the next edge and takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous counter clear |
| in_valid_i | input | W | Slot holds an instruction (slot 0 oldest) |
| in_uops_i | input | W x UOP_W | Micro-op count per slot, 1..W |
| in_dst_i | input | W | Slot writes a destination register |
| in_kind_i | input | W x 2 | 0 other, 1 load, 2 store |
| in_solo_i | input | W | Instruction must dispatch alone |
| rob_free_i | input | CRED_W | Free reorder-buffer entries |
| reg_free_i | input | CRED_W | Free rename registers |
| sched_free_i | input | CRED_W | Free scheduler entries |
| lq_free_i | input | CRED_W | Free load-queue entries |
| sq_free_i | input | CRED_W | Free store-queue entries |
| take_o | output | W | Slots accepted this cycle |
| grp_uops_o | output | clog2(W+1) | Micro-ops dispatched this cycle |
| cause_o | output | 3 | Stall cause code of this cycle |
| stall_cnt_o | output | 6 x CNT_W | Stall counters, index = code-1 |
| hist_o | output | (W+1) x CNT_W | Dispatch-count histogram |

## Verification
The bench builds two instances. The first uses an explicit width of 4, 16-bit counters and a finite rename file, which leaves room to mix several budgets in one four-slot group and to test cause priority. The second uses a width setting of 0, unlimited rename registers and 3-bit counters. With it the default width of 2 and the ignored register budget can be seen, and saturation at 7 is reached within ten cycles.

// File: rtl/disp_pkg.sv
`timescale 1ns/1ps
package disp_pkg;
  typedef enum logic [2:0] {
    CS_NONE  = 3'd0,
    CS_ROB   = 3'd1,
    CS_REG   = 3'd2,
    CS_SCHED = 3'd3,
    CS_LQ    = 3'd4,
    CS_SQ    = 3'd5,
    CS_GROUP = 3'd6
  } cause_e;

  localparam int NCAUSE = 6;
  localparam logic [1:0] K_LOAD  = 2'd1;
  localparam logic [1:0] K_STORE = 2'd2;
endpackage

// File: rtl/disp_sat_cnt.sv
`timescale 1ns/1ps
module disp_sat_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (clr_i)                cnt_o <= '0;
    else if (inc_i && cnt_o != '1) cnt_o <= cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/disp_slot_check.sv
`timescale 1ns/1ps
module disp_slot_check
  import disp_pkg::*;
#(
  parameter int W       = 4,
  parameter int UOP_W   = 3,
  parameter int CRED_W  = 6,
  parameter int SUM_W   = 8,
  parameter bit REGS_ON = 1'b1,
  parameter bit FIRST   = 1'b0
) (
  input  logic              valid_i,
  input  logic [UOP_W-1:0]  uops_i,
  input  logic              dst_i,
  input  logic [1:0]        kind_i,
  input  logic              solo_i,
  input  logic              prev_solo_i,
  input  logic [SUM_W-1:0]  used_uops_i,
  input  logic [SUM_W-1:0]  used_regs_i,
  input  logic [SUM_W-1:0]  used_ld_i,
  input  logic [SUM_W-1:0]  used_st_i,
  input  logic [CRED_W-1:0] rob_free_i,
  input  logic [CRED_W-1:0] reg_free_i,
  input  logic [CRED_W-1:0] sched_free_i,
  input  logic [CRED_W-1:0] lq_free_i,
  input  logic [CRED_W-1:0] sq_free_i,
  output logic              ok_o,
  output cause_e            cause_o,
  output logic [SUM_W-1:0]  nxt_uops_o,
  output logic [SUM_W-1:0]  nxt_regs_o,
  output logic [SUM_W-1:0]  nxt_ld_o,
  output logic [SUM_W-1:0]  nxt_st_o
);
  logic is_ld, is_st;
  logic wid_ok, rob_ok, reg_ok, sch_ok, ld_ok, st_ok, grp_ok;

  // Sums assume every older slot is taken; only used when that holds.
  always_comb begin
    is_ld      = (kind_i == K_LOAD);
    is_st      = (kind_i == K_STORE);
    nxt_uops_o = used_uops_i + SUM_W'(uops_i);
    nxt_regs_o = used_regs_i + SUM_W'(dst_i);
    nxt_ld_o   = used_ld_i + SUM_W'(is_ld);
    nxt_st_o   = used_st_i + SUM_W'(is_st);
    wid_ok     = nxt_uops_o <= SUM_W'(W);
    rob_ok     = nxt_uops_o <= SUM_W'(rob_free_i);
    reg_ok     = !REGS_ON || !dst_i || (nxt_regs_o <= SUM_W'(reg_free_i));
    sch_ok     = nxt_uops_o <= SUM_W'(sched_free_i);
    ld_ok      = !is_ld || (nxt_ld_o <= SUM_W'(lq_free_i));
    st_ok      = !is_st || (nxt_st_o <= SUM_W'(sq_free_i));
    grp_ok     = FIRST || !(solo_i || prev_solo_i);
    ok_o       = valid_i && wid_ok && rob_ok && reg_ok && sch_ok && ld_ok && st_ok && grp_ok;

    if (!valid_i || !wid_ok) cause_o = CS_NONE;
    else if (!rob_ok)        cause_o = CS_ROB;
    else if (!reg_ok)        cause_o = CS_REG;
    else if (!sch_ok)        cause_o = CS_SCHED;
    else if (!ld_ok)         cause_o = CS_LQ;
    else if (!st_ok)         cause_o = CS_SQ;
    else if (!grp_ok)        cause_o = CS_GROUP;
    else                     cause_o = CS_NONE;
  end
endmodule

// File: rtl/disp_ctrl.sv
`timescale 1ns/1ps
module disp_ctrl
  import disp_pkg::*;
#(
  parameter int WIDTH_CFG   = 4,
  parameter int DEF_WIDTH   = 2,
  parameter int UOP_W       = 3,
  parameter int CRED_W      = 6,
  parameter int CNT_W       = 16,
  parameter int RENAME_REGS = 32,
  localparam int W  = (WIDTH_CFG == 0) ? DEF_WIDTH : WIDTH_CFG,
  localparam int GW = $clog2(W + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic [W-1:0]              in_valid_i,
  input  logic [W-1:0][UOP_W-1:0]   in_uops_i,
  input  logic [W-1:0]              in_dst_i,
  input  logic [W-1:0][1:0]         in_kind_i,
  input  logic [W-1:0]              in_solo_i,
  input  logic [CRED_W-1:0]         rob_free_i,
  input  logic [CRED_W-1:0]         reg_free_i,
  input  logic [CRED_W-1:0]         sched_free_i,
  input  logic [CRED_W-1:0]         lq_free_i,
  input  logic [CRED_W-1:0]         sq_free_i,
  output logic [W-1:0]              take_o,
  output logic [GW-1:0]             grp_uops_o,
  output logic [2:0]                cause_o,
  output logic [NCAUSE-1:0][CNT_W-1:0] stall_cnt_o,
  output logic [W:0][CNT_W-1:0]     hist_o
);
  localparam int PW    = UOP_W + $clog2(W + 1);
  localparam int SUM_W = ((CRED_W > PW) ? CRED_W : PW) + 1;
  localparam bit REGS_ON = (RENAME_REGS != 0);

  logic [SUM_W-1:0] su [W+1];
  logic [SUM_W-1:0] sr [W+1];
  logic [SUM_W-1:0] sl [W+1];
  logic [SUM_W-1:0] ss [W+1];
  logic [W-1:0]     ok;
  logic [W-1:0]     prev_solo;
  cause_e           slot_cause [W];
  logic [2:0]       cause_l;
  logic [SUM_W-1:0] acc;

  assign su[0] = '0;
  assign sr[0] = '0;
  assign sl[0] = '0;
  assign ss[0] = '0;

  for (genvar i = 0; i < W; i++) begin : g_slot
    if (i == 0) begin : g_first
      assign prev_solo[i] = 1'b0;
    end else begin : g_rest
      assign prev_solo[i] = in_solo_i[i-1];
    end
    disp_slot_check #(
      .W(W), .UOP_W(UOP_W), .CRED_W(CRED_W), .SUM_W(SUM_W),
      .REGS_ON(REGS_ON), .FIRST(i == 0)
    ) u_chk (
      .valid_i(in_valid_i[i]), .uops_i(in_uops_i[i]), .dst_i(in_dst_i[i]),
      .kind_i(in_kind_i[i]), .solo_i(in_solo_i[i]), .prev_solo_i(prev_solo[i]),
      .used_uops_i(su[i]), .used_regs_i(sr[i]), .used_ld_i(sl[i]), .used_st_i(ss[i]),
      .rob_free_i(rob_free_i), .reg_free_i(reg_free_i), .sched_free_i(sched_free_i),
      .lq_free_i(lq_free_i), .sq_free_i(sq_free_i),
      .ok_o(ok[i]), .cause_o(slot_cause[i]),
      .nxt_uops_o(su[i+1]), .nxt_regs_o(sr[i+1]), .nxt_ld_o(sl[i+1]), .nxt_st_o(ss[i+1])
    );
  end

  // Prefix acceptance; cause comes from the first refused slot.
  always_comb begin
    logic run;
    logic found;
    run     = 1'b1;
    found   = 1'b0;
    acc     = '0;
    cause_l = 3'(CS_NONE);
    for (int i = 0; i < W; i++) begin
      run       = run && ok[i];
      take_o[i] = run;
      if (run) acc = acc + SUM_W'(in_uops_i[i]);
      if (!run && !found) begin
        found   = 1'b1;
        cause_l = 3'(slot_cause[i]);
      end
    end
  end

  assign grp_uops_o = GW'(acc);
  assign cause_o    = cause_l;

  for (genvar c = 0; c < NCAUSE; c++) begin : g_stall
    disp_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
      .inc_i(cause_l == 3'(c + 1)), .cnt_o(stall_cnt_o[c])
    );
  end

  for (genvar b = 0; b <= W; b++) begin : g_hist
    disp_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
      .inc_i(grp_uops_o == GW'(b)), .cnt_o(hist_o[b])
    );
  end
endmodule

// File: rtl/disp_ctrl_chk.sv
`timescale 1ns/1ps
module disp_ctrl_chk #(
  parameter int WIDTH_CFG = 4,
  parameter int DEF_WIDTH = 2,
  parameter int CRED_W    = 6,
  parameter int CNT_W     = 16,
  localparam int W  = (WIDTH_CFG == 0) ? DEF_WIDTH : WIDTH_CFG,
  localparam int GW = $clog2(W + 1)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  clr_i,
  input logic [W-1:0]          in_valid_i,
  input logic [CRED_W-1:0]     rob_free_i,
  input logic [CRED_W-1:0]     sched_free_i,
  input logic [W-1:0]          take_o,
  input logic [GW-1:0]         grp_uops_o,
  input logic [2:0]            cause_o,
  input logic [5:0][CNT_W-1:0] stall_cnt_o,
  input logic [W:0][CNT_W-1:0] hist_o
);
  assert_prefix_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((take_o & (take_o + W'(1))) == '0));

  assert_valid_only_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((take_o & ~in_valid_i) == '0));

  assert_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(grp_uops_o) <= W));

  assert_rob_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(grp_uops_o) <= 32'(rob_free_i)));

  assert_sched_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(grp_uops_o) <= 32'(sched_free_i)));

  assert_cause_refusal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o != 3'd0) |-> (take_o != in_valid_i));

  for (genvar c = 0; c < 6; c++) begin : g_sc
    assert_stall_inc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cause_o == 3'(c + 1) && !clr_i && stall_cnt_o[c] != '1)
      |=> (stall_cnt_o[c] == $past(stall_cnt_o[c]) + CNT_W'(1)));
  end

  assert_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (stall_cnt_o == '0 && hist_o == '0));
endmodule

bind disp_ctrl disp_ctrl_chk #(
  .WIDTH_CFG(WIDTH_CFG), .DEF_WIDTH(DEF_WIDTH), .CRED_W(CRED_W), .CNT_W(CNT_W)
) u_prop (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .in_valid_i(in_valid_i),
  .rob_free_i(rob_free_i), .sched_free_i(sched_free_i), .take_o(take_o),
  .grp_uops_o(grp_uops_o), .cause_o(cause_o), .stall_cnt_o(stall_cnt_o), .hist_o(hist_o)
);

// File: tb/sim_disp_ctrl.sv
`timescale 1ns/1ps
module sim_disp_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  // instance u0: width 4, finite rename file, 16-bit counters
  logic            clr_a = 1'b0;
  logic [3:0]      a_valid;
  logic [3:0][2:0] a_uops;
  logic [3:0]      a_dst;
  logic [3:0][1:0] a_kind;
  logic [3:0]      a_solo;
  logic [5:0]      a_rob, a_reg, a_sch, a_lq, a_sq;
  logic [3:0]      a_take;
  logic [2:0]      a_grp;
  logic [2:0]      a_cause;
  logic [5:0][15:0] a_stall;
  logic [4:0][15:0] a_hist;

  disp_ctrl #(.WIDTH_CFG(4), .CNT_W(16), .RENAME_REGS(32)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr_a),
    .in_valid_i(a_valid), .in_uops_i(a_uops), .in_dst_i(a_dst), .in_kind_i(a_kind),
    .in_solo_i(a_solo), .rob_free_i(a_rob), .reg_free_i(a_reg), .sched_free_i(a_sch),
    .lq_free_i(a_lq), .sq_free_i(a_sq), .take_o(a_take), .grp_uops_o(a_grp),
    .cause_o(a_cause), .stall_cnt_o(a_stall), .hist_o(a_hist)
  );

  // instance u1: width setting 0 (default 2), unlimited registers, 3-bit counters
  logic            clr_b = 1'b0;
  logic [1:0]      b_valid;
  logic [1:0][2:0] b_uops;
  logic [1:0]      b_dst;
  logic [1:0][1:0] b_kind;
  logic [1:0]      b_solo;
  logic [5:0]      b_rob, b_reg;
  logic [1:0]      b_take;
  logic [1:0]      b_grp;
  logic [2:0]      b_cause;
  logic [5:0][2:0] b_stall;
  logic [2:0][2:0] b_hist;

  disp_ctrl #(.WIDTH_CFG(0), .DEF_WIDTH(2), .CNT_W(3), .RENAME_REGS(0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr_b),
    .in_valid_i(b_valid), .in_uops_i(b_uops), .in_dst_i(b_dst), .in_kind_i(b_kind),
    .in_solo_i(b_solo), .rob_free_i(b_rob), .reg_free_i(b_reg), .sched_free_i(6'd63),
    .lq_free_i(6'd63), .sq_free_i(6'd63), .take_o(b_take), .grp_uops_o(b_grp),
    .cause_o(b_cause), .stall_cnt_o(b_stall), .hist_o(b_hist)
  );

  int m_stall [6];
  int m_hist [5];

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic a_idle();
    a_valid = '0; a_dst = '0; a_kind = '0; a_solo = '0;
    for (int i = 0; i < 4; i++) a_uops[i] = 3'd1;
    a_rob = 6'd63; a_reg = 6'd63; a_sch = 6'd63; a_lq = 6'd63; a_sq = 6'd63;
  endtask

  task automatic a_cnt_check(string req);
    for (int c = 0; c < 6; c++) check({req, " stall counter"}, int'(a_stall[c]), m_stall[c]);
    for (int b = 0; b < 5; b++) check({req, " histogram"}, int'(a_hist[b]), m_hist[b]);
  endtask

  // check combinational result, advance one edge, check counters
  task automatic a_step(string req, int e_take, int e_uops, int e_cause);
    #1;
    check({req, " take"}, int'(a_take), e_take);
    check({req, " group uops"}, int'(a_grp), e_uops);
    check({req, " cause"}, int'(a_cause), e_cause);
    m_hist[e_uops]++;
    if (e_cause != 0) m_stall[e_cause-1]++;
    @(posedge clk); #1;
    a_cnt_check("R9/R10 counts");
  endtask

  task automatic t_reset();
    a_idle();
    #1;
    a_cnt_check("R11 reset");
    check("R1 reset take", int'(a_take), 0);
  endtask

  task automatic t_order();
    a_idle(); a_valid = 4'hF;
    a_step("R1 all one-uop", 4'hF, 4, 0);
    a_uops[0] = 3'd2; a_uops[2] = 3'd2;
    a_step("R2 width stop", 4'h3, 3, 0);
    a_idle(); a_valid = 4'b1101;
    a_step("R1 gap in valid", 4'h1, 1, 0);
  endtask

  task automatic t_rob();
    a_idle(); a_valid = 4'hF; a_rob = 6'd2;
    a_step("R3 rob limit", 4'h3, 2, 1);
  endtask

  task automatic t_reg();
    a_idle(); a_valid = 4'hF; a_dst = 4'hF; a_reg = 6'd1;
    a_step("R4 reg limit", 4'h1, 1, 2);
    a_dst = 4'b0101;
    a_step("R4 no-dst slot free", 4'h3, 2, 2);
  endtask

  task automatic t_sched();
    a_idle(); a_valid = 4'hF; a_sch = 6'd3; a_uops[2] = 3'd2;
    a_step("R5 sched limit", 4'h3, 2, 3);
  endtask

  task automatic t_lsq();
    a_idle(); a_valid = 4'hF;
    a_kind[0] = 2'd1; a_kind[1] = 2'd1; a_kind[2] = 2'd2; a_kind[3] = 2'd2;
    a_lq = 6'd1; a_sq = 6'd1;
    a_step("R6 load queue", 4'h1, 1, 4);
    a_lq = 6'd2;
    a_step("R6 store queue", 4'h7, 3, 5);
  endtask

  task automatic t_prio();
    a_idle(); a_valid = 4'h1; a_dst = 4'h1; a_rob = 6'd1; a_reg = 6'd0;
    a_step("R8 reg after rob pass", 0, 0, 2);
    a_rob = 6'd0; a_sch = 6'd0; a_lq = 6'd0; a_kind[0] = 2'd1;
    a_step("R8 rob wins", 0, 0, 1);
    a_rob = 6'd63; a_reg = 6'd63;
    a_step("R8 sched before lq", 0, 0, 3);
  endtask

  task automatic t_solo();
    a_idle(); a_valid = 4'hF; a_solo = 4'b0010;
    a_step("R7 solo not first", 4'h1, 1, 6);
    a_solo = 4'b0001;
    a_step("R7 solo first alone", 4'h1, 1, 6);
    a_solo = 4'b0010; a_rob = 6'd1;
    a_step("R7 rob before group", 4'h1, 1, 1);
  endtask

  task automatic t_clear();
    a_idle(); a_valid = 4'hF; clr_a = 1'b1;
    @(posedge clk); #1;
    clr_a = 1'b0;
    foreach (m_stall[c]) m_stall[c] = 0;
    foreach (m_hist[b]) m_hist[b] = 0;
    a_cnt_check("R11 clear");
    a_step("R11 count after clear", 4'hF, 4, 0);
  endtask

  task automatic t_default();
    b_valid = 2'b11; b_uops[0] = 3'd1; b_uops[1] = 3'd1; b_dst = 2'b11;
    b_kind = '0; b_solo = '0; b_rob = 6'd63; b_reg = 6'd0;
    #1;
    check("R4 unlimited regs take", int'(b_take), 3);
    check("R2 default width uops", int'(b_grp), 2);
    b_uops[0] = 3'd2;
    #1;
    check("R2 default width stop", int'(b_take), 1);
    check("R8 width no cause", int'(b_cause), 0);
  endtask

  task automatic t_sat();
    b_uops[0] = 3'd1; b_rob = 6'd63; clr_b = 1'b1;
    @(posedge clk); #1;
    clr_b = 1'b0;
    repeat (9) @(posedge clk);
    #1;
    check("R11 histogram saturates", int'(b_hist[2]), 7);
    check("R10 idle bin unused", int'(b_hist[0]), 0);
    b_rob = 6'd0; clr_b = 1'b1;
    @(posedge clk); #1;
    clr_b = 1'b0;
    repeat (10) @(posedge clk);
    #1;
    check("R11 stall saturates", int'(b_stall[0]), 7);
    check("R10 zero-dispatch bin", int'(b_hist[0]), 7);
  endtask

  initial begin
    b_valid = '0; b_uops = '0; b_dst = '0; b_kind = '0; b_solo = '0;
    b_rob = 6'd63; b_reg = 6'd63;
    foreach (m_stall[c]) m_stall[c] = 0;
    foreach (m_hist[b]) m_hist[b] = 0;
    a_idle();
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_order();
    t_rob();
    t_reg();
    t_sched();
    t_lsq();
    t_prio();
    t_solo();
    t_clear();
    t_default();
    t_sat();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule